// File: doc/BRIEF.md
# Two-Operand Arctangent Front End: Special Cases and Octant Steering

This block sits ahead of the arithmetic core of a single-precision two-operand arctangent unit. Each cycle with `in_valid` high carries one operand pair. The first operand is the horizontal coordinate `in_x` and the second is the vertical coordinate `in_y`. The block sorts each operand into NaN, infinity, signed zero or finite nonzero. Subnormal encodings count as finite nonzero.

When the pair falls into the IEEE special-case table, the block produces the final 32-bit result itself and raises `out_special`. The pair then needs no further work.

For every other pair, the block steers the core. It says which quotient to form, y/x or x/y, so that the quotient never exceeds 1 in magnitude. It says whether to negate the core's arctangent. It also gives the signed constant the core must add: zero, π/2 or π. The choice is made by octant, so the offset and the core result never cancel. All outputs are registered and appear one cycle after the pair.

Top module: `atan2_front`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, and low otherwise. The data outputs keep their last values while no pair arrives.
- R2: If x is a NaN (exponent all ones, mantissa nonzero), the result is x bit for bit. Otherwise, if y is a NaN, the result is y bit for bit. Both cases set `out_special`.
- R3: When x is +infinity, the result carries the sign of y. It is π/4 when y is infinite and zero otherwise.
- R4: When x is -infinity, the result carries the sign of y. It is 3π/4 when y is infinite and π otherwise.
- R5: When y is infinite and x is finite (zero included), the result is π/2 with the sign of y.
- R6: When x is zero of either sign and y is finite nonzero, the result is π/2 with the sign of y.
- R7: When y is zero and x is finite, the result carries the sign of y. It is zero when x's sign bit is clear and π when it is set.
- R8: The constants are π = 0x40490FDB, π/2 = 0x3FC90FDB, π/4 = 0x3F490FDB and 3π/4 = 0x4016CBE4. A sign is applied by overwriting bit 31. While `out_special` is high, `out_use_xy`, `out_negate`, `out_ofs_sel` and `out_ofs_neg` are all zero.
- R9: For finite nonzero x and y with |y| ≤ |x|, the block does the following. It compares magnitudes as the unsigned bits 30:0, and equal magnitudes take this branch. It drives `out_special`=0, `out_result`=0, `out_use_xy`=0 (use y/x) and `out_negate`=0. For positive x, the offset code `out_ofs_sel` is 00 (none) with `out_ofs_neg`=0. For negative x, the code is 10 (π) with `out_ofs_neg` equal to y's sign.
- R10: For finite nonzero x and y with |y| > |x|, the block drives `out_special`=0, `out_result`=0, `out_use_xy`=1 (use x/y) and `out_negate`=1. The offset code is 01 (π/2), with `out_ofs_neg` equal to y's sign.
- R11: A subnormal operand (exponent zero, mantissa nonzero) is treated as a finite nonzero value in R6, R7, R9 and R10.
- R12: While reset is asserted, `out_valid` and all data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| in_x | input | 32 | Horizontal operand x, single precision |
| in_y | input | 32 | Vertical operand y, single precision |
| out_valid | output | 1 | Registered result present |
| out_special | output | 1 | Pair was resolved by the special-case table |
| out_result | output | 32 | Final result for special pairs, zero otherwise |
| out_use_xy | output | 1 | 1: core uses x/y, 0: core uses y/x |
| out_negate | output | 1 | Core arctangent is subtracted from the offset |
| out_ofs_sel | output | 2 | Offset code: 00 none, 01 π/2, 10 π |
| out_ofs_neg | output | 1 | Offset takes a negative sign |

## Verification
Every result, whether special or steering, is due on the first rising edge after the pair is presented. It is read at the falling edge that follows that rising edge. The bench drives each pair on a falling edge and, at the next falling edge, compares the previous pair's outputs before it drives the next pair, so back-to-back pairs are checked one cycle apart. After the last pair of a stream, a further falling edge confirms that `out_valid` has dropped and that the data outputs held their last values. The operand set covers every pairing of signed zeros, infinities, NaNs with different payloads, subnormals, equal magnitudes and both orderings of magnitude.

// File: rtl/atan2_pkg.sv
package atan2_pkg;

   localparam int FP_W   = 32;
   localparam int FP_EXP = 8;
   localparam int FP_MAN = 23;

   // single-precision constants, sign bit clear
   localparam logic [FP_W-1:0] K_PI      = 32'h40490FDB;
   localparam logic [FP_W-1:0] K_HALF_PI = 32'h3FC90FDB;
   localparam logic [FP_W-1:0] K_QTR_PI  = 32'h3F490FDB;
   localparam logic [FP_W-1:0] K_3QTR_PI = 32'h4016CBE4;
   localparam logic [FP_W-1:0] K_ZERO    = 32'h00000000;

   typedef struct packed {
      logic nan;
      logic inf;
      logic zero;
      logic sign;
   } opclass_t;

   typedef enum logic [1:0] {
      OFS_NONE    = 2'b00,
      OFS_HALF_PI = 2'b01,
      OFS_PI      = 2'b10
   } ofs_e;

   typedef struct packed {
      logic            special;
      logic [FP_W-1:0] result;
      logic            use_xy;
      logic            negate;
      ofs_e            ofs;
      logic            ofs_neg;
   } stage_t;

   function automatic logic [FP_W-1:0] put_sign(input logic [FP_W-1:0] v, input logic s);
      return {s, v[FP_W-2:0]};
   endfunction

endpackage

// File: rtl/atan2_opclass.sv
module atan2_opclass
   import atan2_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0]   op,
   output opclass_t               cls,
   output logic [EXP_W+MAN_W-1:0] mag
);
   localparam int W = 1 + EXP_W + MAN_W;

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic             exp_max;
   logic             exp_min;
   logic             man_nz;

   assign exp_f   = op[W-2:MAN_W];
   assign man_f   = op[MAN_W-1:0];
   assign exp_max = &exp_f;
   assign exp_min = ~|exp_f;
   assign man_nz  = |man_f;

   always_comb begin
      cls.sign = op[W-1];
      cls.nan  = exp_max & man_nz;
      cls.inf  = exp_max & ~man_nz;
      // subnormals fall through as finite nonzero
      cls.zero = exp_min & ~man_nz;
   end

   assign mag = op[W-2:0];

endmodule

// File: rtl/atan2_special.sv
module atan2_special
   import atan2_pkg::*;
(
   input  logic [FP_W-1:0] x,
   input  logic [FP_W-1:0] y,
   input  opclass_t        xc,
   input  opclass_t        yc,
   output logic            is_special,
   output logic [FP_W-1:0] result
);
   logic x_fin;
   logic y_fin_nz;

   assign x_fin    = ~xc.nan & ~xc.inf;
   assign y_fin_nz = ~yc.nan & ~yc.inf & ~yc.zero;

   always_comb begin
      is_special = 1'b1;
      result     = K_ZERO;
      if (xc.nan) begin
         result = x;
      end else if (yc.nan) begin
         result = y;
      end else if (xc.inf && !xc.sign) begin
         result = put_sign(yc.inf ? K_QTR_PI : K_ZERO, yc.sign);
      end else if (xc.inf && xc.sign) begin
         result = put_sign(yc.inf ? K_3QTR_PI : K_PI, yc.sign);
      end else if (yc.inf) begin
         result = put_sign(K_HALF_PI, yc.sign);
      end else if (xc.zero && y_fin_nz) begin
         result = put_sign(K_HALF_PI, yc.sign);
      end else if (yc.zero && x_fin) begin
         result = put_sign(xc.sign ? K_PI : K_ZERO, yc.sign);
      end else begin
         is_special = 1'b0;
         result     = K_ZERO;
      end
   end

endmodule

// File: rtl/atan2_octant.sv
module atan2_octant
   import atan2_pkg::*;
#(
   parameter int MAG_W = 31
) (
   input  logic [MAG_W-1:0] xmag,
   input  logic [MAG_W-1:0] ymag,
   input  logic             xsign,
   input  logic             ysign,
   output logic             use_xy,
   output logic             negate,
   output ofs_e             ofs,
   output logic             ofs_neg
);
   logic steep;

   // sign-stripped encodings order like the magnitudes; a tie stays shallow
   assign steep = ymag > xmag;

   always_comb begin
      use_xy  = steep;
      negate  = steep;
      ofs_neg = 1'b0;
      ofs     = OFS_NONE;
      if (steep) begin
         ofs     = OFS_HALF_PI;
         ofs_neg = ysign;
      end else if (xsign) begin
         ofs     = OFS_PI;
         ofs_neg = ysign;
      end
   end

endmodule

// File: rtl/atan2_front.sv
module atan2_front
   import atan2_pkg::*;
#(
   parameter int EXP_W     = 8,
   parameter int MAN_W     = 23,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [31:0] in_x,
   input  logic [31:0] in_y,
   output logic        out_valid,
   output logic        out_special,
   output logic [31:0] out_result,
   output logic        out_use_xy,
   output logic        out_negate,
   output logic [1:0]  out_ofs_sel,
   output logic        out_ofs_neg
);
   localparam int W     = 1 + EXP_W + MAN_W;
   localparam int MAG_W = W - 1;
   localparam int N_OP  = 2;

   generate
      if (EXP_W != FP_EXP || MAN_W != FP_MAN) begin : g_bad_fmt
         $error("atan2_front: constants are single precision only");
      end
   endgenerate

   logic [W-1:0]     ops [N_OP];
   opclass_t         cls [N_OP];
   logic [MAG_W-1:0] mag [N_OP];

   assign ops[0] = in_x;
   assign ops[1] = in_y;

   generate
      for (genvar g = 0; g < N_OP; g++) begin : g_cls
         atan2_opclass #(
            .EXP_W(EXP_W),
            .MAN_W(MAN_W)
         ) u_cls (
            .op (ops[g]),
            .cls(cls[g]),
            .mag(mag[g])
         );
      end
   endgenerate

   logic        sp_hit;
   logic [31:0] sp_res;

   atan2_special u_spec (
      .x         (in_x),
      .y         (in_y),
      .xc        (cls[0]),
      .yc        (cls[1]),
      .is_special(sp_hit),
      .result    (sp_res)
   );

   logic oc_use_xy;
   logic oc_negate;
   ofs_e oc_ofs;
   logic oc_ofs_neg;

   atan2_octant #(
      .MAG_W(MAG_W)
   ) u_oct (
      .xmag   (mag[0]),
      .ymag   (mag[1]),
      .xsign  (cls[0].sign),
      .ysign  (cls[1].sign),
      .use_xy (oc_use_xy),
      .negate (oc_negate),
      .ofs    (oc_ofs),
      .ofs_neg(oc_ofs_neg)
   );

   stage_t nxt;
   stage_t cur;
   logic   vld_q;

   always_comb begin
      nxt.special = sp_hit;
      nxt.result  = sp_res;
      nxt.use_xy  = oc_use_xy & ~sp_hit;
      nxt.negate  = oc_negate & ~sp_hit;
      nxt.ofs     = sp_hit ? OFS_NONE : oc_ofs;
      nxt.ofs_neg = oc_ofs_neg & ~sp_hit;
   end

   generate
      if (ASYNC_RST) begin : g_arst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               cur   <= '0;
            end else begin
               vld_q <= in_valid;
               if (in_valid) cur <= nxt;
            end
         end
      end else begin : g_srst
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               cur   <= '0;
            end else begin
               vld_q <= in_valid;
               if (in_valid) cur <= nxt;
            end
         end
      end
   endgenerate

   assign out_valid   = vld_q;
   assign out_special = cur.special;
   assign out_result  = cur.result;
   assign out_use_xy  = cur.use_xy;
   assign out_negate  = cur.negate;
   assign out_ofs_sel = cur.ofs;
   assign out_ofs_neg = cur.ofs_neg;

endmodule

// File: rtl/atan2_front_chk.sv
module atan2_front_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [31:0] in_x,
   input logic [31:0] in_y,
   input logic        out_valid,
   input logic        out_special,
   input logic [31:0] out_result,
   input logic        out_use_xy,
   input logic        out_negate,
   input logic [1:0]  out_ofs_sel,
   input logic        out_ofs_neg
);
   logic x_nan, x_inf, x_zero, y_nan, y_inf, y_zero, both_fin_nz;

   assign x_nan  = (&in_x[30:23]) && (|in_x[22:0]);
   assign x_inf  = (&in_x[30:23]) && !(|in_x[22:0]);
   assign x_zero = in_x[30:0] == 31'd0;
   assign y_nan  = (&in_y[30:23]) && (|in_y[22:0]);
   assign y_inf  = (&in_y[30:23]) && !(|in_y[22:0]);
   assign y_zero = in_y[30:0] == 31'd0;
   assign both_fin_nz = !x_nan && !x_inf && !x_zero && !y_nan && !y_inf && !y_zero;

   // R1
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R1
   vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R2
   nan_x_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && x_nan) |=> (out_special && out_result == $past(in_x)));

   // R5
   y_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && y_inf && !x_nan && !x_inf) |=>
         (out_special && out_result[30:0] == 31'h3FC90FDB && out_result[31] == $past(in_y[31])));

   // R8
   steer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_special) |-> (out_ofs_sel == 2'b00 && !out_use_xy && !out_negate && !out_ofs_neg));

   // R9
   tie_shallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && both_fin_nz && in_x[30:0] == in_y[30:0]) |=>
         (!out_special && !out_use_xy && !out_negate && out_result == 32'd0));

   // R10
   steep_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && both_fin_nz && in_y[30:0] > in_x[30:0]) |=>
         (out_use_xy && out_negate && out_ofs_sel == 2'b01 && out_ofs_neg == $past(in_y[31])));

endmodule

bind atan2_front atan2_front_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_x       (in_x),
   .in_y       (in_y),
   .out_valid  (out_valid),
   .out_special(out_special),
   .out_result (out_result),
   .out_use_xy (out_use_xy),
   .out_negate (out_negate),
   .out_ofs_sel(out_ofs_sel),
   .out_ofs_neg(out_ofs_neg)
);

// File: tb/atan2_front_tb.sv
`timescale 1ns/1ps
module atan2_front_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [31:0] in_x, in_y;
   logic        out_valid, out_special, out_use_xy, out_negate, out_ofs_neg;
   logic [31:0] out_result;
   logic [1:0]  out_ofs_sel;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;

   always #4 clk = ~clk;

   atan2_front u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
      .out_valid(out_valid), .out_special(out_special), .out_result(out_result),
      .out_use_xy(out_use_xy), .out_negate(out_negate),
      .out_ofs_sel(out_ofs_sel), .out_ofs_neg(out_ofs_neg)
   );

   wire [38:0] act = {out_valid, out_special, out_result, out_use_xy,
                      out_negate, out_ofs_sel, out_ofs_neg};

   function automatic logic [31:0] val(input int k);
      case (k)
         0:  return 32'h00000000;
         1:  return 32'h80000000;
         2:  return 32'h7F800000;
         3:  return 32'hFF800000;
         4:  return 32'h7FC00000;
         5:  return 32'hFF800001;
         6:  return 32'h3F800000;
         7:  return 32'hBF800000;
         8:  return 32'h40000000;
         9:  return 32'hBF000000;
         10: return 32'h00000001;
         11: return 32'h80400000;
         12: return 32'h7F7FFFFF;
         default: return 32'hC0000000;
      endcase
   endfunction

   // expected {valid, special, result, use_xy, negate, ofs, ofs_neg}
   function automatic logic [38:0] model(input logic [31:0] x, input logic [31:0] y,
                                         output string tag);
      logic xn, xi, xz, yn, yi, yz, xs, ys, steep, sub;
      logic [31:0] r;
      xn = (&x[30:23]) && (|x[22:0]);
      xi = (&x[30:23]) && !(|x[22:0]);
      xz = x[30:0] == 0;
      yn = (&y[30:23]) && (|y[22:0]);
      yi = (&y[30:23]) && !(|y[22:0]);
      yz = y[30:0] == 0;
      xs = x[31];
      ys = y[31];
      sub = (x[30:23] == 0 && !xz) || (y[30:23] == 0 && !yz);
      if (xn) begin tag = "R2"; r = x; end
      else if (yn) begin tag = "R2"; r = y; end
      else if (xi && !xs) begin tag = "R3"; r = {ys, yi ? 31'h3F490FDB : 31'h0}; end
      else if (xi && xs) begin tag = "R4"; r = {ys, yi ? 31'h4016CBE4 : 31'h40490FDB}; end
      else if (yi) begin tag = "R5"; r = {ys, 31'h3FC90FDB}; end
      else if (xz && !yz) begin tag = sub ? "R11" : "R6"; r = {ys, 31'h3FC90FDB}; end
      else if (yz) begin tag = sub ? "R11" : "R7"; r = {ys, xs ? 31'h40490FDB : 31'h0}; end
      else begin
         steep = y[30:0] > x[30:0];
         tag = sub ? "R11" : (steep ? "R10" : "R9");
         if (steep)   return {1'b1, 1'b0, 32'h0, 1'b1, 1'b1, 2'b01, ys};
         else if (xs) return {1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 2'b10, ys};
         else         return {1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 2'b00, 1'b0};
      end
      return {1'b1, 1'b1, r, 1'b0, 1'b0, 2'b00, 1'b0};
   endfunction

   task automatic check(input string tag, input logic [38:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [38:0] pend;
      string ptag;
      bit have;
      have = 1'b0;
      pend = '0;
      ptag = "";
      rst_n = 1'b0;
      in_valid = 1'b0;
      in_x = '0;
      in_y = '0;
      repeat (3) @(negedge clk);
      // R12 reset state
      check("R12", 39'd0);
      rst_n = 1'b1;

      // back-to-back sweep over all operand pairings
      for (int i = 0; i < 14; i++) begin
         for (int j = 0; j < 14; j++) begin
            @(negedge clk);
            if (have) check(ptag, pend);
            in_x = val(i);
            in_y = val(j);
            in_valid = 1'b1;
            pend = model(val(i), val(j), ptag);
            have = 1'b1;
         end
      end
      @(negedge clk);
      check(ptag, pend);
      in_valid = 1'b0;
      in_x = 32'h3F800000;
      in_y = 32'h7FC00000;
      @(negedge clk);
      // R1 idle: valid drops, data held
      check("R1", {1'b0, pend[37:0]});

      // isolated pairs with idle gaps
      for (int k = 0; k < 14; k++) begin
         @(negedge clk);
         in_x = val(k);
         in_y = val(13 - k);
         in_valid = 1'b1;
         pend = model(val(k), val(13 - k), ptag);
         @(negedge clk);
         in_valid = 1'b0;
         check(ptag, pend);
         @(negedge clk);
         check("R1", {1'b0, pend[37:0]});
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule